// File: doc/BRIEF.md
# FPU Result Forwarding and Hazard Unit

This block sits beside a small in-order pipeline that has a main integer pipe and an attached floating-point execute pipe with three execute stages. Multi-cycle floating-point operations write their destination late: the result exists only from the last execute stage onward, and the register file holds it only after the write-back stage commits. The block keeps a tag (valid bit and destination index) for every operation in flight. It compares these tags with the source register of the instruction about to capture its operand. It then either selects a bypass source or asks the front of the pipeline to wait.

The arithmetic unit shows a finished result on `e3_result` for a single cycle only: the first cycle its producer spends in the last execute stage. A global freeze (`ext_stall`) can land on that stage, and the reader then cannot capture in that cycle. To cover this, the block copies the result into a holding register. It keeps forwarding from that copy, and from a write-back copy, until the register file has been written. The value reaches the reader in the same way whether the reader sends it to an integer register (`rd_to_cpu` = 1) or to a floating-point register (`rd_to_cpu` = 0).

Top module: `fpu_fwd_unit`

## Requirements
- R1: After a cycle with `rst_n` low, no operation is in flight: `stall_req`, `wb_we`, `cpu_opnd_vld` and `fpu_opnd_vld` are 0, and an issue made during reset leaves no trace.
- R2: While `ext_stall` is 1, `iss_vld` is ignored, no tracked operation moves, and `wb_we` is 0.
- R3: A valid issue seen in a cycle with `ext_stall` = 0 is in stage E1 after that edge. Each later cycle with `ext_stall` = 0 moves it one stage (E1, E2, E3, W). `wb_we` is 1, with `wb_idx` equal to its destination, during a cycle in which it is in W and `ext_stall` is 0.
- R4: `stall_req` is 1 exactly when `rd_vld` is 1 and the youngest in-flight operation writing `rd_src` is in E1 or E2.
- R5: When the youngest match for `rd_src` is in its first cycle in E3, the operand is the current `e3_result`.
- R6: When the youngest match stays in E3 because of `ext_stall`, the operand is the value `e3_result` showed in its first E3 cycle. `e3_result` in later cycles is ignored.
- R7: When the youngest match is in W, the operand is that operation's result, not `rf_rdata`.
- R8: When several in-flight operations write `rd_src`, the youngest one (the latest issued) supplies the operand or causes the stall.
- R9: With no in-flight match, the operand is `rf_rdata`.
- R10: The operand is captured at an edge where `rd_vld` = 1, `ext_stall` = 0 and `stall_req` = 0. In the next cycle `opnd_data` holds it, with `cpu_opnd_vld` = 1 if `rd_to_cpu` was 1, or `fpu_opnd_vld` = 1 if it was 0. Otherwise both valids are 0.
- R11: `wb_data` equals the `e3_result` value shown in that operation's first E3 cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_stall | input | 1 | Global pipeline freeze |
| iss_vld | input | 1 | A multi-cycle FPU operation enters E1 |
| iss_dst | input | 3 | Destination register of the issuing operation |
| e3_result | input | 32 | Result from the arithmetic unit, valid in the first E3 cycle |
| rd_vld | input | 1 | A reader wants its operand this cycle |
| rd_src | input | 3 | Source FPU register of the reader |
| rd_to_cpu | input | 1 | 1: reader moves to an integer register; 0: FPU-to-FPU move |
| rf_rdata | input | 32 | FPU register file contents at `rd_src` |
| stall_req | output | 1 | Reader must wait for a result not yet produced |
| wb_we | output | 1 | Register file write enable |
| wb_idx | output | 3 | Register file write index |
| wb_data | output | 32 | Register file write data |
| cpu_opnd_vld | output | 1 | Captured operand goes to an integer register |
| fpu_opnd_vld | output | 1 | Captured operand goes to an FPU register |
| opnd_data | output | 32 | Captured operand |

## Verification
The assertions and the forwarding choice rely on four things about the inputs. `e3_result` carries the producer's value in that producer's first E3 cycle. The register file applies `wb_*` at the edge where they are shown. Nothing is issued while a reader is held by `stall_req`. An issue in the same cycle as a capture is younger than the reader. The bench keeps to all four: its register file and `e3_result` come from its own in-order model, and it puts random values on `e3_result` in every other cycle so that a stale pick shows up. It withdraws `iss_vld` once it sees `stall_req`, and it updates its program-order register image only after the capture has been judged. Stimulus sweeps the issue-to-read gap, the length and position of freezes (including several-cycle freezes over E3), and duplicate writers of the same register. A long random run follows that uses a four-register subset to force collisions.

// File: rtl/fpu_fwd_pkg.sv
// Shared definitions for the FPU forwarding unit.
// Assumes: operand source kinds are ordered by nothing; the encoding is free.
package fpu_fwd_pkg;

    // Where the reader's operand comes from in the current cycle
    typedef enum logic [2:0] {
        SRC_RF      = 3'd0,   // register file, no in-flight writer
        SRC_E3_LIVE = 3'd1,   // arithmetic output, first E3 cycle
        SRC_E3_HOLD = 3'd2,   // holding copy, producer frozen in E3
        SRC_WB      = 3'd3,   // write-back copy, not yet in the file
        SRC_WAIT    = 3'd4    // producer in an early stage, stall
    } fwd_src_e;

endpackage

// File: rtl/fwd_tracker.sv
// Tag shift chain for in-flight multi-cycle FPU operations.
// Slot 0 is E1, the last slot is write-back. Every slot moves one
// position on each cycle with adv high and holds otherwise.
// Assumes: iss_vld is only meaningful when adv is high.
module fwd_tracker #(
    parameter int unsigned IDX_W = 3,
    parameter int unsigned NSLOT = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            adv,
    input  logic                            iss_vld,
    input  logic [IDX_W-1:0]                iss_dst,
    output logic [NSLOT-1:0]                slot_vld,
    output logic [NSLOT-1:0][IDX_W-1:0]     slot_idx
);

    generate
        for (genvar g = 0; g < NSLOT; g++) begin : g_slot
            logic             v_q;
            logic [IDX_W-1:0] i_q;
            if (g == 0) begin : g_head
                // Entry slot: load the issuing operation on advance
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        v_q <= 1'b0;
                        i_q <= '0;
                    end else if (adv) begin
                        v_q <= iss_vld;
                        i_q <= iss_dst;
                    end
                end
            end else begin : g_body
                // Later slot: take the tag of the slot before it on advance
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        v_q <= 1'b0;
                        i_q <= '0;
                    end else if (adv) begin
                        v_q <= slot_vld[g-1];
                        i_q <= slot_idx[g-1];
                    end
                end
            end
            assign slot_vld[g] = v_q;
            assign slot_idx[g] = i_q;
        end
    endgenerate

    // A frozen cycle leaves every tag where it was (R2, R3)
    assert_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !adv) |=> ($stable(slot_vld) && $stable(slot_idx)));

    // A non-frozen cycle moves the head tag one step (R3)
    assert_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && adv) |=> (slot_vld[1] == $past(slot_vld[0])));

endmodule

// File: rtl/fwd_result_hold.sv
// Result capture for the last execute stage and the write-back stage.
// The arithmetic output is trusted only in the first cycle a producer
// spends in E3. That value is copied into a holding register, so that a
// freeze over E3 cannot lose it. It then moves to a write-back copy.
// Assumes: e3_result is valid whenever e3_fresh is high.
module fwd_result_hold #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic              e2_vld,
    input  logic              e3_vld,
    input  logic [DATA_W-1:0] e3_result,
    output logic              e3_fresh,
    output logic [DATA_W-1:0] e3_live,
    output logic [DATA_W-1:0] w_data
);

    logic [DATA_W-1:0] e3_hold;

    // First-cycle flag: set for exactly one cycle after a producer enters E3
    always_ff @(posedge clk) begin
        if (!rst_n)   e3_fresh <= 1'b0;
        else if (adv) e3_fresh <= e2_vld;
        else          e3_fresh <= 1'b0;
    end

    // Holding register: sample the arithmetic output in the first E3 cycle
    always_ff @(posedge clk) begin
        if (!rst_n)        e3_hold <= '0;
        else if (e3_fresh) e3_hold <= e3_result;
    end

    // The valid E3 value: live in the first cycle, held afterwards
    always_comb begin
        e3_live = e3_fresh ? e3_result : e3_hold;
    end

    // Write-back copy: follows the producer out of E3
    always_ff @(posedge clk) begin
        if (!rst_n)   w_data <= '0;
        else if (adv) w_data <= e3_live;
    end

    // A producer frozen in E3 keeps its held result (R6)
    assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !adv && e3_vld && !e3_fresh) |=> $stable(e3_hold));

    // The first-cycle flag never lasts two cycles (R6)
    assert_fresh_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        e3_fresh |=> !e3_fresh || $past(adv));

endmodule

// File: rtl/fwd_match.sv
// Source compare and bypass selection.
// Compares the reader's source index with every in-flight tag. It picks
// the youngest match (lowest slot) and turns its stage into a bypass
// choice or a wait.
// Assumes: slot 0 is the youngest; slots NSLOT-2 and NSLOT-1 are E3 and W.
module fwd_match
    import fpu_fwd_pkg::*;
#(
    parameter int unsigned IDX_W  = 3,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned NSLOT  = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            rd_vld,
    input  logic [IDX_W-1:0]                rd_src,
    input  logic [NSLOT-1:0]                slot_vld,
    input  logic [NSLOT-1:0][IDX_W-1:0]     slot_idx,
    input  logic                            e3_fresh,
    input  logic [DATA_W-1:0]               e3_live,
    input  logic [DATA_W-1:0]               w_data,
    input  logic [DATA_W-1:0]               rf_rdata,
    output fwd_src_e                        sel,
    output logic                            hazard,
    output logic [DATA_W-1:0]               fwd_data
);

    localparam int unsigned POS_W = (NSLOT > 2) ? $clog2(NSLOT) : 1;
    localparam logic [POS_W-1:0] E3_POS = POS_W'(NSLOT - 2);

    logic [NSLOT-1:0] hit_vec;
    logic             found;
    logic [POS_W-1:0] hit_pos;

    generate
        for (genvar g = 0; g < NSLOT; g++) begin : g_cmp
            // Per-slot tag compare
            assign hit_vec[g] = rd_vld && slot_vld[g] && (slot_idx[g] == rd_src);
        end
    endgenerate

    // Youngest-match priority: scan oldest to youngest, last hit wins
    always_comb begin
        found   = 1'b0;
        hit_pos = '0;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                found   = 1'b1;
                hit_pos = POS_W'(i);
            end
        end
    end

    // Stage of the youngest match to bypass source
    always_comb begin
        if (!found)                 sel = SRC_RF;
        else if (hit_pos < E3_POS)  sel = SRC_WAIT;
        else if (hit_pos == E3_POS) sel = e3_fresh ? SRC_E3_LIVE : SRC_E3_HOLD;
        else                        sel = SRC_WB;
    end

    // Bypass multiplexer
    always_comb begin
        case (sel)
            SRC_E3_LIVE,
            SRC_E3_HOLD: fwd_data = e3_live;
            SRC_WB:      fwd_data = w_data;
            default:     fwd_data = rf_rdata;
        endcase
        hazard = (sel == SRC_WAIT);
    end

    // The live arithmetic output is used only in a first E3 cycle (R5)
    assert_live_only_fresh_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SRC_E3_LIVE) |-> e3_fresh);

    // A wait is never raised without a reader (R4)
    assert_wait_needs_reader_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hazard |-> (rd_vld && (slot_vld[0] || slot_vld[1])));

endmodule

// File: rtl/fpu_fwd_unit.sv
// FPU result forwarding and hazard unit (top).
// Tracks multi-cycle FPU operations, supplies each reader the newest
// value of its source register and requests a stall while that value is
// not yet produced. Results stay available through freezes of any length.
// Assumes: the register file applies wb_* at the edge they are shown;
// no issue is made while a reader is held by stall_req.
module fpu_fwd_unit
    import fpu_fwd_pkg::*;
#(
    parameter int unsigned NUM_REGS  = 8,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned EX_STAGES = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ext_stall,
    input  logic                        iss_vld,
    input  logic [$clog2(NUM_REGS)-1:0] iss_dst,
    input  logic [DATA_W-1:0]           e3_result,
    input  logic                        rd_vld,
    input  logic [$clog2(NUM_REGS)-1:0] rd_src,
    input  logic                        rd_to_cpu,
    input  logic [DATA_W-1:0]           rf_rdata,
    output logic                        stall_req,
    output logic                        wb_we,
    output logic [$clog2(NUM_REGS)-1:0] wb_idx,
    output logic [DATA_W-1:0]           wb_data,
    output logic                        cpu_opnd_vld,
    output logic                        fpu_opnd_vld,
    output logic [DATA_W-1:0]           opnd_data
);

    localparam int unsigned IDX_W = $clog2(NUM_REGS);
    localparam int unsigned NSLOT = EX_STAGES + 1;
    localparam int unsigned E2_POS = NSLOT - 3;
    localparam int unsigned E3_POS = NSLOT - 2;
    localparam int unsigned W_POS  = NSLOT - 1;

    logic                        adv;
    logic [NSLOT-1:0]            slot_vld;
    logic [NSLOT-1:0][IDX_W-1:0] slot_idx;
    logic                        e3_fresh;
    logic [DATA_W-1:0]           e3_live;
    logic [DATA_W-1:0]           w_data;
    fwd_src_e                    sel;
    logic                        hazard;
    logic [DATA_W-1:0]           fwd_data;
    logic                        capture;

    // Pipeline motion: everything moves unless frozen
    always_comb begin
        adv     = !ext_stall;
        capture = rd_vld && adv && !hazard;
    end

    fwd_tracker #(.IDX_W(IDX_W), .NSLOT(NSLOT)) u_tracker (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (adv),
        .iss_vld  (iss_vld),
        .iss_dst  (iss_dst),
        .slot_vld (slot_vld),
        .slot_idx (slot_idx)
    );

    fwd_result_hold #(.DATA_W(DATA_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (adv),
        .e2_vld    (slot_vld[E2_POS]),
        .e3_vld    (slot_vld[E3_POS]),
        .e3_result (e3_result),
        .e3_fresh  (e3_fresh),
        .e3_live   (e3_live),
        .w_data    (w_data)
    );

    fwd_match #(.IDX_W(IDX_W), .DATA_W(DATA_W), .NSLOT(NSLOT)) u_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_vld   (rd_vld),
        .rd_src   (rd_src),
        .slot_vld (slot_vld),
        .slot_idx (slot_idx),
        .e3_fresh (e3_fresh),
        .e3_live  (e3_live),
        .w_data   (w_data),
        .rf_rdata (rf_rdata),
        .sel      (sel),
        .hazard   (hazard),
        .fwd_data (fwd_data)
    );

    // Write-back port and stall request
    always_comb begin
        stall_req = hazard;
        wb_we     = slot_vld[W_POS] && adv;
        wb_idx    = slot_idx[W_POS];
        wb_data   = w_data;
    end

    // Operand capture register, routed by reader kind
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_opnd_vld <= 1'b0;
            fpu_opnd_vld <= 1'b0;
            opnd_data    <= '0;
        end else begin
            cpu_opnd_vld <= capture && rd_to_cpu;
            fpu_opnd_vld <= capture && !rd_to_cpu;
            if (capture) opnd_data <= fwd_data;
        end
    end

    // A blocked reader produces no operand next cycle (R10)
    assert_no_capture_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && rd_vld && (ext_stall || stall_req)) |=> !(cpu_opnd_vld || fpu_opnd_vld));

    // An operand goes to one destination kind only (R10)
    assert_single_route_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_opnd_vld && fpu_opnd_vld));

    // No register file write during a freeze (R2)
    assert_wb_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ext_stall |-> !wb_we);

endmodule

// File: tb/tb_fpu_fwd_unit.sv
module tb_fpu_fwd_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_stall = 1'b0;
    logic        iss_vld = 1'b0;
    logic [2:0]  iss_dst = '0;
    logic [31:0] e3_result = '0;
    logic        rd_vld = 1'b0;
    logic [2:0]  rd_src = '0;
    logic        rd_to_cpu = 1'b0;
    logic [31:0] rf_rdata = '0;
    logic        stall_req, wb_we, cpu_opnd_vld, fpu_opnd_vld;
    logic [2:0]  wb_idx;
    logic [31:0] wb_data, opnd_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    string ctx = "";

    // Program-order model
    logic [31:0] rf   [8];
    logic [31:0] arch [8];
    logic        m_vld [4];
    logic [2:0]  m_idx [4];
    logic [31:0] m_val [4];
    logic        m_fresh = 1'b0;

    always #5 clk = ~clk;

    fpu_fwd_unit dut (
        .clk(clk), .rst_n(rst_n), .ext_stall(ext_stall),
        .iss_vld(iss_vld), .iss_dst(iss_dst), .e3_result(e3_result),
        .rd_vld(rd_vld), .rd_src(rd_src), .rd_to_cpu(rd_to_cpu),
        .rf_rdata(rf_rdata), .stall_req(stall_req), .wb_we(wb_we),
        .wb_idx(wb_idx), .wb_data(wb_data), .cpu_opnd_vld(cpu_opnd_vld),
        .fpu_opnd_vld(fpu_opnd_vld), .opnd_data(opnd_data)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s%s at %0t: actual %h expected %h", req, ctx, $time, act, exp);
        end
    endtask

    // One clock cycle of stimulus plus checks against the model
    task automatic step(input logic st, input logic iv, input logic [2:0] id,
                        input logic rv, input logic [2:0] rs, input logic rc,
                        output logic cap);
        int y;
        int nm;
        logic ex_h, ex_cap, iv_eff;
        logic [31:0] ex_d, nv;
        string rq;
        @(negedge clk);
        ext_stall = st; iss_vld = iv; iss_dst = id;
        rd_vld = rv; rd_src = rs; rd_to_cpu = rc;
        e3_result = m_fresh ? m_val[2] : $urandom();
        rf_rdata = rf[rs];
        y = -1; nm = 0;
        for (int i = 3; i >= 0; i--)
            if (m_vld[i] && m_idx[i] == rs) begin y = i; nm++; end
        ex_h = rv && (y == 0 || y == 1);
        #1;
        chk(stall_req == ex_h, "R4 stall_req", 32'(stall_req), 32'(ex_h));
        iv_eff = iv && !ex_h;
        if (ex_h) iss_vld = 1'b0;
        chk(wb_we == (m_vld[3] && !st), "R3 wb_we", 32'(wb_we), 32'(m_vld[3] && !st));
        if (m_vld[3] && !st) begin
            chk(wb_idx == m_idx[3], "R3 wb_idx", 32'(wb_idx), 32'(m_idx[3]));
            chk(wb_data == m_val[3], "R11 wb_data", wb_data, m_val[3]);
        end
        ex_cap = rv && !st && !ex_h;
        ex_d = arch[rs];
        if (y < 0)                 rq = "R9 rf operand";
        else if (y == 2 && m_fresh) rq = "R5 live E3 operand";
        else if (y == 2)           rq = "R6 held E3 operand";
        else                       rq = "R7 wb operand";
        if (nm > 1) rq = {rq, " R8 youngest"};
        @(posedge clk);
        if (!st) begin
            if (m_vld[3]) rf[m_idx[3]] = m_val[3];
            for (int i = 3; i > 0; i--) begin
                m_vld[i] = m_vld[i-1]; m_idx[i] = m_idx[i-1]; m_val[i] = m_val[i-1];
            end
            m_fresh = m_vld[2];
            nv = $urandom();
            m_vld[0] = iv_eff; m_idx[0] = id; m_val[0] = nv;
            if (iv_eff) arch[id] = nv;
        end else begin
            m_fresh = 1'b0;
        end
        #1;
        chk(cpu_opnd_vld == (ex_cap && rc), "R10 cpu route", 32'(cpu_opnd_vld), 32'(ex_cap && rc));
        chk(fpu_opnd_vld == (ex_cap && !rc), "R10 fpu route", 32'(fpu_opnd_vld), 32'(ex_cap && !rc));
        if (ex_cap) chk(opnd_data == ex_d, rq, opnd_data, ex_d);
        cap = ex_cap;
    endtask

    task automatic drain();
        logic c;
        for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 3'd0, 1'b0, 3'd0, 1'b0, c);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic c;
        logic pend;
        logic [2:0] ps;
        logic pc;
        int burst;
        for (int i = 0; i < 8; i++) begin
            rf[i] = 32'h1000_0000 + 32'(i); arch[i] = rf[i];
        end
        for (int i = 0; i < 4; i++) begin
            m_vld[i] = 1'b0; m_idx[i] = '0; m_val[i] = '0;
        end
        // Reset with an issue and a reader present
        iss_vld = 1'b1; iss_dst = 3'd5; rd_vld = 1'b1; rd_src = 3'd5;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        chk(stall_req == 1'b0, "R1 stall_req", 32'(stall_req), 0);
        chk(wb_we == 1'b0, "R1 wb_we", 32'(wb_we), 0);
        chk(!(cpu_opnd_vld || fpu_opnd_vld), "R1 operand valid", 32'(cpu_opnd_vld | fpu_opnd_vld), 0);
        iss_vld = 1'b0; rd_vld = 1'b0; rst_n = 1'b1;
        ctx = " R1 post-reset";
        step(1'b0, 1'b0, 3'd0, 1'b1, 3'd5, 1'b1, c);
        drain();

        // Issue during a freeze must leave no trace
        ctx = " R2 ignored issue";
        step(1'b1, 1'b1, 3'd6, 1'b0, 3'd0, 1'b0, c);
        step(1'b0, 1'b0, 3'd0, 1'b1, 3'd6, 1'b0, c);
        drain();
        ctx = "";

        // Sweep: duplicate writer, read gap, freeze length and position
        for (int dup = 0; dup < 2; dup++)
            for (int gap = 0; gap < 6; gap++)
                for (int sl = 0; sl < 4; sl++)
                    for (int sp = 0; sp < 6; sp++) begin
                        drain();
                        if (dup == 1) step(1'b0, 1'b1, 3'd3, 1'b0, 3'd0, 1'b0, c);
                        step(1'b0, 1'b1, 3'd3, 1'b0, 3'd0, 1'b0, c);
                        c = 1'b0;
                        for (int t = 0; t < 20 && !c; t++)
                            step((t >= sp) && (t < sp + sl), 1'b0, 3'd0,
                                 t >= gap, 3'd3, 1'(gap & 1), c);
                    end
        drain();

        // Random run over four registers with freeze bursts
        pend = 1'b0; ps = '0; pc = 1'b0; burst = 0;
        for (int n = 0; n < 4000; n++) begin
            logic st;
            if (burst > 0) begin st = 1'b1; burst--; end
            else begin
                st = ($urandom() % 100) < 15;
                if (($urandom() % 100) < 8) burst = 1 + int'($urandom() % 4);
            end
            if (!pend && ($urandom() % 100) < 55) begin
                pend = 1'b1; ps = 3'($urandom() % 4); pc = 1'($urandom());
            end
            step(st, 1'($urandom()), 3'($urandom() % 4), pend, ps, pc, c);
            if (c) pend = 1'b0;
        end
        drain();

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule